// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Controller

This block sits between an on-chip requester and an asynchronous 16-bit DRAM array of 1024 rows by 256 columns. The DRAM has one CAS strobe and two write enables, one per byte. The controller accepts one word access at a time through a valid/ready pair. It splits the word address into a row half and a column half and presents them one after the other on a shared 10-bit address bus. A synchronous state machine sequences the RAS, CAS, OE and the two write-enable strobes.

A page-mode enable input lets the controller hold a row open after an access. A following request to the same row then costs only a new column address and one CAS pulse. The page is closed, with RAS raised for the precharge time, in four cases: the next request targets another row, page mode is switched off, a refresh falls due, or a higher-priority bus owner raises the preempt input. A free-running timer requests CAS-before-RAS refresh cycles. These take priority over new accesses.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no request, RAS, CAS, OE and both write enables are high (inactive), the data bus is not driven and no response is signalled.
- R2: The request address is split with bits [17:8] as the row and bits [7:0] as the column. The row appears on `dram_a` while RAS is low and CAS is high before the column phase. The column, zero-extended to 10 bits, appears while CAS is low, so every word is stored and read at its own row and column.
- R3: With `page_en` high, consecutive accesses to the same row produce a single RAS falling edge; each later access is one CAS pulse with a new column.
- R4: With `page_en` low, every access opens and closes its own row. In page mode, a request to a different row first closes the open row. RAS stays high for at least T_RP (1) cycles before it falls, and stays low for at least T_RCD (1) cycles before an access CAS falls.
- R5: A refresh is requested every REF_INTERVAL cycles. In a refresh, CAS falls one cycle before RAS, RAS stays low for exactly T_RAS_REF (3) cycles, and OE and both write enables stay high.
- R6: A read drives OE low with both write enables high. The data bus is sampled on the last CAS cycle, and `rsp_valid` pulses for one cycle in the cycle after that, with the word on `rsp_rdata`.
- R7: A write uses a single CAS pulse with OE high and the data bus driven. The upper write enable follows `req_be[1]` (bits 15:8) and the lower follows `req_be[0]` (bits 7:0); an unselected byte keeps its old value.
- R8: Raising `preempt` ends an open page. The next access, even to the same row, activates the row again.
- R9: In page mode, 256 consecutive writes to all columns of one row complete under one row activation, apart from reopenings forced by refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| page_en | input | 1 | Keep a row open between accesses when high |
| preempt | input | 1 | Higher-priority bus owner wants the bus; closes an open page |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted on this clock edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| req_addr | input | 18 | Word address: row in [17:8], column in [7:0] |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_uwe_n | output | 1 | Upper-byte write enable, active low |
| dram_lwe_n | output | 1 | Lower-byte write enable, active low |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_dq_o | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_o` |
| dram_dq_i | input | 16 | Data from the DRAM |

## Verification
The bench drives the controller against a behavioural DRAM model that latches rows on RAS and counts row activations and refreshes. It first runs writes and reads with page mode off, where each access must cost one activation. It then runs same-row bursts in page mode, where one activation must suffice. Alternating-row traffic shows whether the row comparison really closes a page on a miss. A preempt in the middle of a burst, and a 256-column burst, separate a page that is held open from one that is reopened. Partial byte-enable writes followed by read-back show lane steering, and a long idle stretch checks refresh rate and strobe order.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_CAS,
    ST_OPEN,
    ST_PRE,
    ST_RCAS,
    ST_RRAS
  } fpm_state_e;

  typedef enum logic [1:0] {
    AS_ZERO,
    AS_ROW,
    AS_COL
  } addr_sel_e;

endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
  parameter int INTERVAL = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic due
);
  localparam int CW = $clog2(INTERVAL);
  localparam logic [CW-1:0] LOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          tick;

  assign tick = (cnt_q == '0);

  always_comb begin
    cnt_d  = tick ? LOAD : cnt_q - 1'b1;
    pend_d = pend_q;
    if (tick)     pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LOAD;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign due = pend_q;
endmodule

// File: rtl/fpm_page_track.sv
module fpm_page_track #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic [ROW_W-1:0] row_in,
  input  logic [ROW_W-1:0] req_row,
  output logic             hit
);
  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q;

  always_comb begin
    open_d = open_q;
    if (clear)     open_d = 1'b0;
    else if (load) open_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else begin
      open_q <= open_d;
      if (load) row_q <= row_in;
    end
  end

  assign hit = open_q && (row_q == req_row);
endmodule

// File: rtl/fpm_addr_mux.sv
module fpm_addr_mux import fpm_pkg::*; #(
  parameter int ROW_W = 10,
  parameter int COL_W = 8,
  parameter int A_W   = 10
) (
  input  addr_sel_e        sel,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic [A_W-1:0]   a
);
  always_comb begin
    case (sel)
      AS_ROW:  a = A_W'(row);
      AS_COL:  a = A_W'(col);
      default: a = '0;
    endcase
  end
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq import fpm_pkg::*; #(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 16,
  parameter int T_RCD     = 1,
  parameter int T_CAS     = 1,
  parameter int T_RP      = 1,
  parameter int T_RAS_REF = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_en,
  input  logic              preempt,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [1:0]        req_be,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              page_hit,
  input  logic              ref_due,
  output logic              accept,
  output logic              ref_ack,
  output logic              page_load,
  output logic              page_clear,
  output addr_sel_e         addr_sel,
  output logic [ROW_W-1:0]  cur_row,
  output logic [COL_W-1:0]  cur_col,
  output logic              ras_n,
  output logic              cas_n,
  output logic              oe_n,
  output logic              uwe_n,
  output logic              lwe_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int T_M1  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int T_M2  = (T_RP > T_RAS_REF) ? T_RP : T_RAS_REF;
  localparam int T_MAX = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_CAS = CNT_W'(T_CAS - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_REF = CNT_W'(T_RAS_REF - 1);

  fpm_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_zero;
  logic              we_q;
  logic [1:0]        be_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              last_rd;
  logic              close_page;

  assign cnt_zero   = (cnt_q == '0);
  assign close_page = ref_due || preempt || !page_en || (req_valid && !page_hit);

  // next-state process
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    accept     = 1'b0;
    ref_ack    = 1'b0;
    page_load  = 1'b0;
    page_clear = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ref_due) begin
          state_d = ST_RCAS;
          ref_ack = 1'b1;
        end else if (req_valid) begin
          accept    = 1'b1;
          page_load = 1'b1;
          state_d   = ST_ACT;
          cnt_d     = LD_RCD;
        end
      end
      ST_ACT: begin
        if (cnt_zero) begin
          state_d = ST_CAS;
          cnt_d   = LD_CAS;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_CAS: begin
        if (cnt_zero) begin
          if (page_en && !preempt && !ref_due) begin
            state_d = ST_OPEN;
          end else begin
            state_d    = ST_PRE;
            cnt_d      = LD_RP;
            page_clear = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_OPEN: begin
        if (close_page) begin
          state_d    = ST_PRE;
          cnt_d      = LD_RP;
          page_clear = 1'b1;
        end else if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_CAS;
          cnt_d   = LD_CAS;
        end
      end
      ST_PRE: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_RCAS: begin
        state_d = ST_RRAS;
        cnt_d   = LD_REF;
      end
      ST_RRAS: begin
        if (cnt_zero) begin
          state_d = ST_PRE;
          cnt_d   = LD_RP;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign last_rd = (state_q == ST_CAS) && cnt_zero && !we_q;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      cur_row  <= '0;
      cur_col  <= '0;
      we_q     <= 1'b0;
      be_q     <= '0;
      wd_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      rvalid_q <= last_rd;
      if (accept) begin
        cur_row <= req_row;
        cur_col <= req_col;
        we_q    <= req_we;
        be_q    <= req_be;
        wd_q    <= req_wdata;
      end
      if (last_rd) rdata_q <= dq_i;
    end
  end

  // strobe decode from the registered state
  always_comb begin
    ras_n    = !((state_q == ST_ACT) || (state_q == ST_CAS) ||
                 (state_q == ST_OPEN) || (state_q == ST_RRAS));
    cas_n    = !((state_q == ST_CAS) || (state_q == ST_RCAS) || (state_q == ST_RRAS));
    oe_n     = !((state_q == ST_CAS) && !we_q);
    uwe_n    = !((state_q == ST_CAS) && we_q && be_q[1]);
    lwe_n    = !((state_q == ST_CAS) && we_q && be_q[0]);
    dq_oe    = (state_q == ST_CAS) && we_q;
    case (state_q)
      ST_ACT:           addr_sel = AS_ROW;
      ST_CAS, ST_OPEN:  addr_sel = AS_COL;
      default:          addr_sel = AS_ZERO;
    endcase
  end

  assign dq_o      = wd_q;
  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl import fpm_pkg::*; #(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 16,
  parameter int T_RCD        = 1,
  parameter int T_CAS        = 1,
  parameter int T_RP         = 1,
  parameter int T_RAS_REF    = 3,
  parameter int REF_INTERVAL = 512,
  localparam int ADDR_W      = ROW_W + COL_W,
  localparam int A_W         = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_en,
  input  logic              preempt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [1:0]        req_be,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_oe_n,
  output logic              dram_uwe_n,
  output logic              dram_lwe_n,
  output logic [A_W-1:0]    dram_a,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_i
);
  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             ref_due, ref_ack;
  logic             page_hit, page_load, page_clear;
  addr_sel_e        addr_sel;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign req_row = req_addr[ADDR_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  fpm_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ack   (ref_ack),
    .due   (ref_due)
  );

  fpm_page_track #(.ROW_W(ROW_W)) u_page (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (page_load),
    .clear   (page_clear),
    .row_in  (req_row),
    .req_row (req_row),
    .hit     (page_hit)
  );

  fpm_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS_REF(T_RAS_REF)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .page_en    (page_en),
    .preempt    (preempt),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .req_be     (req_be),
    .req_row    (req_row),
    .req_col    (req_col),
    .req_wdata  (req_wdata),
    .page_hit   (page_hit),
    .ref_due    (ref_due),
    .accept     (req_ready),
    .ref_ack    (ref_ack),
    .page_load  (page_load),
    .page_clear (page_clear),
    .addr_sel   (addr_sel),
    .cur_row    (cur_row),
    .cur_col    (cur_col),
    .ras_n      (dram_ras_n),
    .cas_n      (dram_cas_n),
    .oe_n       (dram_oe_n),
    .uwe_n      (dram_uwe_n),
    .lwe_n      (dram_lwe_n),
    .dq_o       (dram_dq_o),
    .dq_oe      (dram_dq_oe),
    .dq_i       (dram_dq_i),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  fpm_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W)) u_amux (
    .sel (addr_sel),
    .row (cur_row),
    .col (cur_col),
    .a   (dram_a)
  );
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RCD     = 1,
  parameter int T_RP      = 1,
  parameter int T_RAS_REF = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic oe_n,
  input logic uwe_n,
  input logic lwe_n,
  input logic dq_oe,
  input logic rsp_valid
);
  logic [7:0] hi_cnt;
  logic [7:0] lo_cnt;
  logic       ref_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      ref_flag <= 1'b0;
    end else begin
      hi_cnt <= ras_n ? ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1) : 8'd0;
      lo_cnt <= !ras_n ? ((lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1) : 8'd0;
      if (ras_n) ref_flag <= !cas_n;
    end
  end

  p_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= 8'(T_RP));

  p_ras_to_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> lo_cnt >= 8'(T_RCD));

  p_cbr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  p_cbr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> (uwe_n && lwe_n && oe_n));

  p_cbr_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && ref_flag) |-> lo_cnt == 8'(T_RAS_REF));

  p_read_no_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (uwe_n && lwe_n));

  p_rsp_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!cas_n) && $past(!oe_n)));

  p_strobe_in_cas_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!uwe_n || !lwe_n || !oe_n) |-> (!cas_n && !ras_n));

  p_drive_no_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS_REF(T_RAS_REF)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .ras_n     (dram_ras_n),
  .cas_n     (dram_cas_n),
  .oe_n      (dram_oe_n),
  .uwe_n     (dram_uwe_n),
  .lwe_n     (dram_lwe_n),
  .dq_oe     (dram_dq_oe),
  .rsp_valid (rsp_valid)
);

// File: tb/fpm_dram_ctrl_tb_top.sv
module fpm_dram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REF_INT    = 100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        page_en, preempt, req_valid, req_ready, req_we;
  logic [1:0]  req_be;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        dram_ras_n, dram_cas_n, dram_oe_n, dram_uwe_n, dram_lwe_n;
  logic [9:0]  dram_a;
  logic [15:0] dram_dq_o;
  logic        dram_dq_oe;
  logic [15:0] dram_dq_i = 16'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpm_dram_ctrl #(.REF_INTERVAL(REF_INT)) dut_i (
    .clk(clk), .rst_n(rst_n), .page_en(page_en), .preempt(preempt),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_oe_n(dram_oe_n),
    .dram_uwe_n(dram_uwe_n), .dram_lwe_n(dram_lwe_n), .dram_a(dram_a),
    .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ---------------- DRAM model ----------------
  logic [15:0] model_mem [int];
  logic [15:0] shadow    [int];
  logic [9:0]  m_row = '0;
  bit          m_prev_ras = 1;
  bit          m_prev_cas = 1;
  bit          m_in_ref = 0;
  int          m_ras_lo = 0;
  int          act_cnt = 0;
  int          ref_cnt = 0;
  int          ref_err = 0;
  int          bus_err = 0;

  function automatic logic [15:0] model_rd(input int k);
    return model_mem.exists(k) ? model_mem[k] : 16'h0;
  endfunction

  function automatic logic [15:0] shadow_rd(input int k);
    return shadow.exists(k) ? shadow[k] : 16'h0;
  endfunction

  always @(posedge clk) begin
    logic [15:0] w;
    int k;
    if (m_prev_ras && !dram_ras_n) begin
      if (!dram_cas_n) begin
        ref_cnt++;
        m_in_ref = 1;
        if (m_prev_cas) ref_err++;
      end else begin
        act_cnt++;
        m_in_ref = 0;
        m_row = dram_a;
      end
    end
    if (!dram_ras_n) m_ras_lo++;
    else begin
      if (!m_prev_ras && m_in_ref && m_ras_lo != 3) ref_err++;
      if (!m_prev_ras) m_in_ref = 0;
      m_ras_lo = 0;
    end
    if (!dram_cas_n && (!dram_uwe_n || !dram_lwe_n || !dram_oe_n) &&
        (dram_ras_n || m_in_ref)) ref_err++;
    if (!dram_oe_n && (!dram_uwe_n || !dram_lwe_n)) bus_err++;
    if (!dram_ras_n && !dram_cas_n && !m_in_ref && (!dram_uwe_n || !dram_lwe_n)) begin
      if (!dram_dq_oe) bus_err++;
      k = int'({m_row, dram_a[7:0]});
      w = model_rd(k);
      if (!dram_uwe_n) w[15:8] = dram_dq_o[15:8];
      if (!dram_lwe_n) w[7:0]  = dram_dq_o[7:0];
      model_mem[k] = w;
    end
    m_prev_ras = dram_ras_n;
    m_prev_cas = dram_cas_n;
  end

  always @(negedge clk) begin
    if (!dram_oe_n) dram_dq_i = model_rd(int'({m_row, dram_a[7:0]}));
  end

  // ---------------- scoreboard ----------------
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (rsp_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(0, "R6 unexpected response", int'(rsp_rdata), 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_rdata == e, t, int'(rsp_rdata), int'(e));
      end
    end
  end

  task automatic access(input bit we, input logic [1:0] be, input logic [9:0] row,
                        input logic [7:0] col, input logic [15:0] d, input string tag);
    int k;
    logic [15:0] w;
    k = int'({row, col});
    req_we = we; req_be = be; req_addr = {row, col}; req_wdata = d; req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    if (we) begin
      w = shadow_rd(k);
      if (be[1]) w[15:8] = d[15:8];
      if (be[0]) w[7:0]  = d[7:0];
      shadow[k] = w;
    end else begin
      exp_q.push_back(shadow_rd(k));
      tag_q.push_back(tag);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    int a0, r0, da, dr;
    rst_n = 1'b0; page_en = 1'b0; preempt = 1'b0; req_valid = 1'b0;
    req_we = 1'b0; req_be = 2'b00; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    chk({dram_ras_n, dram_cas_n, dram_oe_n, dram_uwe_n, dram_lwe_n, dram_dq_oe, rsp_valid} == 7'b1111100,
        "R1 strobes in reset", int'({dram_ras_n, dram_cas_n, dram_oe_n, dram_uwe_n, dram_lwe_n, dram_dq_oe, rsp_valid}), 'h7c);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({dram_ras_n, dram_cas_n, dram_oe_n, dram_uwe_n, dram_lwe_n, dram_dq_oe, rsp_valid} == 7'b1111100,
        "R1 strobes idle after reset", int'({dram_ras_n, dram_cas_n, dram_oe_n, dram_uwe_n, dram_lwe_n, dram_dq_oe, rsp_valid}), 'h7c);

    // R2 / R4: page mode off, every access opens its own row
    a0 = act_cnt;
    for (int i = 0; i < 4; i++) access(1, 2'b11, 10'd5 + 10'(i), 8'(i * 37), 16'h1000 + 16'(i), "R2");
    for (int i = 0; i < 4; i++) access(0, 2'b00, 10'd5 + 10'(i), 8'(i * 37), 16'h0, "R2 read back");
    access(1, 2'b11, 10'h3ff, 8'hff, 16'hbeef, "R2");
    access(0, 2'b00, 10'h3ff, 8'hff, 16'h0, "R2 top corner");
    drain();
    chk(act_cnt - a0 == 10, "R4 one activation per access without page mode", act_cnt - a0, 10);

    // R7: byte lanes
    access(1, 2'b11, 10'd7, 8'd9, 16'haaaa, "R7");
    access(1, 2'b01, 10'd7, 8'd9, 16'h1234, "R7");
    access(1, 2'b10, 10'd7, 8'd9, 16'h5600, "R7");
    access(1, 2'b00, 10'd7, 8'd9, 16'hffff, "R7");
    access(0, 2'b00, 10'd7, 8'd9, 16'h0, "R7 merged bytes");
    drain();
    chk(model_rd(int'({10'd7, 8'd9})) == 16'h5634, "R7 stored word",
        int'(model_rd(int'({10'd7, 8'd9}))), 'h5634);

    // R3: page mode, same row
    page_en = 1'b1;
    a0 = act_cnt; r0 = ref_cnt;
    for (int i = 0; i < 6; i++) access(1, 2'b11, 10'd20, 8'(i), 16'h2000 + 16'(i * 5), "R3");
    for (int i = 0; i < 6; i++) access(0, 2'b00, 10'd20, 8'(i), 16'h0, "R3 page read");
    drain();
    da = act_cnt - a0; dr = ref_cnt - r0;
    chk(da >= 1 && da <= 1 + dr, "R3 single activation for same-row burst", da, 1);

    // R4: alternating rows in page mode
    a0 = act_cnt; r0 = ref_cnt;
    for (int i = 0; i < 4; i++) access(1, 2'b11, 10'd30 + 10'(i % 2), 8'd3, 16'h3000 + 16'(i), "R4");
    access(0, 2'b00, 10'd30, 8'd3, 16'h0, "R4 row 30");
    access(0, 2'b00, 10'd31, 8'd3, 16'h0, "R4 row 31");
    drain();
    da = act_cnt - a0; dr = ref_cnt - r0;
    chk(da >= 6 && da <= 6 + dr, "R4 row miss reopens", da, 6);

    // R8: preempt closes an open page
    page_en = 1'b0;
    repeat (4) @(negedge clk);
    page_en = 1'b1;
    a0 = act_cnt; r0 = ref_cnt;
    access(1, 2'b11, 10'd40, 8'd1, 16'h4001, "R8");
    preempt = 1'b1;
    repeat (3) @(negedge clk);
    preempt = 1'b0;
    access(1, 2'b11, 10'd40, 8'd2, 16'h4002, "R8");
    access(0, 2'b00, 10'd40, 8'd1, 16'h0, "R8 read");
    drain();
    da = act_cnt - a0; dr = ref_cnt - r0;
    chk(da >= 2 && da <= 2 + dr, "R8 reactivation after preempt", da, 2);

    // R9: full-row burst
    page_en = 1'b0;
    repeat (4) @(negedge clk);
    page_en = 1'b1;
    a0 = act_cnt; r0 = ref_cnt;
    for (int c = 0; c < 256; c++) access(1, 2'b11, 10'd100, 8'(c), 16'(c * 3 + 7), "R9");
    drain();
    da = act_cnt - a0; dr = ref_cnt - r0;
    chk(da >= 1 && da <= 1 + dr, "R9 activations for 256-word burst", da, 1);
    access(0, 2'b00, 10'd100, 8'd0, 16'h0, "R9 col 0");
    access(0, 2'b00, 10'd100, 8'd128, 16'h0, "R9 col 128");
    access(0, 2'b00, 10'd100, 8'd255, 16'h0, "R9 col 255");
    drain();
    page_en = 1'b0;

    // R5: refresh while idle
    repeat (4) @(negedge clk);
    r0 = ref_cnt;
    repeat (5 * REF_INT) @(negedge clk);
    dr = ref_cnt - r0;
    chk(dr >= 4 && dr <= 6, "R5 refresh rate", dr, 5);
    chk(ref_err == 0, "R5 refresh strobe order and width", ref_err, 0);
    chk(bus_err == 0, "R6 OE/WE exclusion and data drive", bus_err, 0);
    access(0, 2'b00, 10'd5, 8'd0, 16'h0, "R5 data kept over refresh");
    drain();
    chk(exp_q.size() == 0, "R6 all reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule